// File: doc/BRIEF.md
# Match-Compare OS Timer with Watchdog

This block is a 32-bit up-counter that advances on each cycle where an external tick enable is high. Four compare registers sit beside it. When a tick carries the counter onto a compare value, the channel's event can latch into a sticky status bit and drive that channel's interrupt line. Software clears these bits by writing ones. Compare channel 3 can also act as a one-shot watchdog. If its arm bit is set when channel 3 fires, the block pulses a system reset request and disarms itself.

All state is reached through a simple bus with separate read and write strobes. The address is a word index. Reads are combinational and return the selected register in the same cycle. A read of an unmapped index returns zero, and a one-cycle error flag follows it. The tick rate is set outside the block, for example 3.6864 MHz or 3.25 MHz, so the block stays independent of the clock tree.

Top module: `os_match_timer`

## Requirements
- R1: After reset, the counter, all compare registers, the status, the interrupt mask and the watchdog arm bit read as zero, and `irq`, `sys_rst_req` and `bus_err` are low.
- R2: The counter (word index 4) rises by exactly one at each clock edge where `tick_en` is high, and holds otherwise. A bus write loads the written value, takes priority over a tick in the same cycle, and counting resumes from that value.
- R3: The counter wraps from 0xFFFFFFFF to 0. A compare value below the current count fires once the counter has wrapped and reaches it.
- R4: When a tick moves the counter onto compare register n (word index n, n = 0..3) and mask bit n is 1, status bit n sets at that same edge. `irq[n]` is high while status bit n is set. With mask bit n at 0 the status bit stays 0.
- R5: An event needs a tick step onto the compare value, so there is at most one event per pass. Loading the counter with a value equal to a compare register creates no event.
- R6: Writing the status register (word index 5, bits 3:0) clears every bit written as 1 and leaves bits written as 0 untouched. A cleared channel's `irq` bit falls at that edge.
- R7: The interrupt mask (word index 7) keeps only bits 11:0, and higher bits read as zero. Bits 3:0 gate channels 0 to 3.
- R8: The watchdog arm bit is bit 0 of word index 6. A channel-3 event while armed raises `sys_rst_req` for exactly one cycle and clears the arm bit at the same edge, whatever mask bit 3 holds. When not armed, no request is raised.
- R9: Reading any word index other than 0 to 7 returns zero, and `bus_err` is high for the one cycle after that read. Mapped reads leave `bus_err` low. Writes to unmapped indices change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_err | output | 1 | Unmapped-read flag, one cycle |
| irq | output | 4 | Per-channel interrupt lines |
| sys_rst_req | output | 1 | Watchdog reset request pulse |

## Verification
The hardest condition to reach from the ports is a compare hit that happens only after the counter wraps. Counting there from reset would take 2^32 ticks. The bench instead loads the counter a few steps below 0xFFFFFFFF, stops the tick enable, and then issues an exact number of ticks. This places the wrap and the hit on known cycles. The watchdog is driven the same way: the counter is parked just below the channel-3 value, and the test counts the request pulses seen on `sys_rst_req`.

// File: rtl/os_match_timer.sv
module os_match_timer #(
  parameter int CNT_W   = 32,
  parameter int N_CH    = 4,
  parameter int IE_W    = 12,
  parameter int AW      = 6,
  parameter int WDOG_CH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             bus_err,
  output logic [N_CH-1:0]  irq,
  output logic             sys_rst_req
);
  localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int W_CNT  = 4;
  localparam int W_STAT = 5;
  localparam int W_WDOG = 6;
  localparam int W_IE   = 7;

  logic [N_CH-1:0][CNT_W-1:0] match_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [N_CH-1:0]  stat_q, hit;
  logic [IE_W-1:0]  ie_q;
  logic             wdog_q, req_q, err_q, mapped;

  wire wr_cnt  = bus_wr && (bus_addr == AW'(W_CNT));
  wire wr_stat = bus_wr && (bus_addr == AW'(W_STAT));
  wire wr_wdog = bus_wr && (bus_addr == AW'(W_WDOG));
  wire wr_ie   = bus_wr && (bus_addr == AW'(W_IE));

  assign cnt_nxt = cnt_q + CNT_W'(1);
  assign mapped  = (int'(bus_addr) < N_CH) ||
                   (int'(bus_addr) >= W_CNT && int'(bus_addr) <= W_IE);

  always_comb begin
    for (int i = 0; i < N_CH; i++)
      hit[i] = tick_en && !wr_cnt && (cnt_nxt == match_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (wr_cnt) cnt_q <= bus_wdata;
    else if (tick_en) cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) match_q <= '0;
    else for (int i = 0; i < N_CH; i++)
      if (bus_wr && bus_addr == AW'(i)) match_q[i] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else for (int i = 0; i < N_CH; i++) begin
      if (hit[i] && ie_q[i]) stat_q[i] <= 1'b1;
      else if (wr_stat && bus_wdata[i]) stat_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ie_q <= '0;
    else if (wr_ie) ie_q <= bus_wdata[IE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdog_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (wr_wdog) wdog_q <= bus_wdata[0];
      if (hit[WDOG_CH] && wdog_q) begin
        wdog_q <= 1'b0;
        req_q  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else err_q <= bus_rd && !mapped;
  end

  always_comb begin
    bus_rdata = '0;
    if (int'(bus_addr) < N_CH) bus_rdata = match_q[bus_addr[CH_W-1:0]];
    else case (int'(bus_addr))
      W_CNT:  bus_rdata = cnt_q;
      W_STAT: bus_rdata[N_CH-1:0] = stat_q;
      W_WDOG: bus_rdata[0] = wdog_q;
      W_IE:   bus_rdata[IE_W-1:0] = ie_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq         = stat_q;
  assign sys_rst_req = req_q;
  assign bus_err     = err_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_cnt) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_cnt) |=> $stable(cnt_q)); // R2
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !tick_en) |=> (stat_q & $past(bus_wdata[N_CH-1:0])) == '0); // R6
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req); // R8
  AST_REQ_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> !wdog_q); // R8
  AST_ERR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_rd)); // R9

  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    AST_EVT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[g]) |-> $past(ie_q[g] && tick_en)); // R4
  end
endmodule

// File: tb/os_match_timer_test.sv
module os_match_timer_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_err, sys_rst_req;
  logic [3:0]  irq;
  int checks = 0, fails = 0, pulses = 0;
  logic [31:0] rv;
  logic        ev;

  os_match_timer uut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq(irq), .sys_rst_req(sys_rst_req));

  always #(PERIOD/2) clk = ~clk;
  always @(negedge clk) if (sys_rst_req) pulses++;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d, output logic e);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0; e = bus_err;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic expect_reg(input logic [5:0] a, input logic [31:0] exp, input string tag);
    rd(a, rv, ev);
    check(rv == exp, tag, rv, exp);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) expect_reg(6'(i), 32'h0, "R1 register zero after reset");
    check(irq == 4'h0 && !sys_rst_req && !bus_err, "R1 outputs low", {irq, sys_rst_req, bus_err}, 0);
  endtask

  task automatic t_count;
    wr(6'd4, 32'd100);
    ticks(5);
    expect_reg(6'd4, 32'd105, "R2 five ticks");
    repeat (3) @(negedge clk);
    expect_reg(6'd4, 32'd105, "R2 hold without tick");
    @(negedge clk); tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 6'd4; bus_wdata = 32'd1000;
    @(negedge clk); tick_en = 1'b0; bus_wr = 1'b0;
    expect_reg(6'd4, 32'd1000, "R2 write wins over tick");
    ticks(2);
    expect_reg(6'd4, 32'd1002, "R2 resumes from written value");
  endtask

  task automatic t_wrap;
    wr(6'd7, 32'h1);
    wr(6'd0, 32'h0);
    wr(6'd4, 32'hFFFF_FFFE);
    ticks(1);
    check(irq[0] == 1'b0, "R3 no event before wrap", irq, 0);
    ticks(1);
    expect_reg(6'd4, 32'h0, "R3 counter wrapped");
    check(irq[0] == 1'b1, "R3 match below count after wrap", irq, 1);
    ticks(1);
    expect_reg(6'd4, 32'h1, "R3 counts on after wrap");
  endtask

  task automatic t_match;
    wr(6'd7, 32'h3);
    wr(6'd1, 32'd50);
    wr(6'd4, 32'd45);
    ticks(4);
    check(irq[1] == 1'b0, "R4 not yet at compare", irq, 0);
    ticks(1);
    expect_reg(6'd5, 32'h3, "R4 status bits 0 and 1");
    check(irq == 4'h3, "R4 irq follows status", irq, 4'h3);
    wr(6'd2, 32'd60);
    wr(6'd4, 32'd55);
    ticks(10);
    expect_reg(6'd5, 32'h3, "R4 masked channel 2 sets nothing");
    check(irq[2] == 1'b0, "R4 masked irq low", irq, 0);
  endtask

  task automatic t_clear;
    wr(6'd5, 32'h0);
    expect_reg(6'd5, 32'h3, "R6 zero write keeps bits");
    wr(6'd5, 32'h1);
    expect_reg(6'd5, 32'h2, "R6 one write clears bit 0 only");
    check(irq == 4'h2, "R6 irq 0 dropped", irq, 4'h2);
    wr(6'd5, 32'hF);
    check(irq == 4'h0, "R6 all cleared", irq, 0);
  endtask

  task automatic t_single;
    wr(6'd4, 32'd48);
    ticks(6);
    check(irq[1] == 1'b1, "R5 event on step", irq, 4'h2);
    wr(6'd5, 32'h2);
    ticks(20);
    expect_reg(6'd5, 32'h0, "R5 one event per pass");
    wr(6'd4, 32'd50);
    repeat (2) @(negedge clk);
    expect_reg(6'd5, 32'h0, "R5 load onto compare gives no event");
  endtask

  task automatic t_mask;
    wr(6'd7, 32'hFFFF_FFFF);
    expect_reg(6'd7, 32'h0000_0FFF, "R7 mask keeps 12 bits");
    wr(6'd7, 32'h0);
  endtask

  task automatic t_watchdog;
    int p0;
    wr(6'd3, 32'd200);
    wr(6'd4, 32'd195);
    p0 = pulses;
    ticks(5);
    @(negedge clk);
    check(pulses == p0, "R8 disarmed gives no request", pulses, p0);
    wr(6'd6, 32'h1);
    expect_reg(6'd6, 32'h1, "R8 arm bit reads back");
    wr(6'd4, 32'd195);
    p0 = pulses;
    ticks(5);
    repeat (3) @(negedge clk);
    check(pulses == p0 + 1, "R8 exactly one request cycle", pulses, p0 + 1);
    expect_reg(6'd6, 32'h0, "R8 arm bit self-cleared");
    expect_reg(6'd5, 32'h0, "R8 masked channel 3 status stays clear");
  endtask

  task automatic t_unmapped;
    rd(6'd8, rv, ev);
    check(rv == 32'h0, "R9 unmapped read data", rv, 0);
    check(ev == 1'b1, "R9 error after unmapped read", ev, 1);
    @(negedge clk);
    check(bus_err == 1'b0, "R9 error lasts one cycle", bus_err, 0);
    rd(6'd1, rv, ev);
    check(ev == 1'b0, "R9 mapped read no error", ev, 0);
    wr(6'd9, 32'hDEAD_BEEF);
    expect_reg(6'd0, 32'h0, "R9 unmapped write harmless m0");
    expect_reg(6'd1, 32'd50, "R9 unmapped write harmless m1");
    expect_reg(6'd7, 32'h0, "R9 unmapped write harmless mask");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_count;
    t_wrap;
    t_match;
    t_clear;
    t_single;
    t_mask;
    t_watchdog;
    t_unmapped;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: bench timed out");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule